// File: doc/BRIEF.md
# Fifth-Order Integrator-Comb Decimator with Stepped-Down Integrator Widths

This block lowers the sample rate of a narrow oversampled stream, such as the bit-stream of a sigma-delta modulator, by a factor of 16. It also removes the out-of-band quantisation noise that would otherwise alias into the band. The transfer function is ((1 - z^-16)/(1 - z^-1))^5. It has no multipliers and no coefficient storage.

Five integrators run at the input rate. Each integrator is narrower than the one before it, because the lowest bits of its predecessor are dropped. A phase counter picks one integrator result in every 16 valid samples and hands it to five 16-bit difference stages. These stages run at the output rate. The integrator chain is pipelined without extra flops: every integrator adds the registered value of the stage before it.

For a full-precision design, the word growth is 5·log2(16) = 20 bits, which gives a 25-bit first stage for a 5-bit input. The output holds the top 16 of those 25 bits. A dc input of A therefore settles near A·2048, apart from the truncation error.

Top module: `cic_decim`

## Requirements
- R1: A synchronous reset clears every integrator, every comb delay, the phase counter and the output register. While reset is held and in the cycle after, `outValid` is 0 and `outData` is 0.
- R2: `inData` is a 5-bit two's-complement sample. It is sign-extended to 25 bits and added into the first integrator on each clock with `inValid` high.
- R3: The integrators are 25, 22, 20, 18 and 16 bits wide, from first to last. The addend of each stage is the top bits of the previous stage: 3, 2, 2 and 2 LSBs are dropped. All sums wrap modulo their width, with no saturation.
- R4: The addend of integrator k+1 is the registered value of integrator k as it stood before the current clock edge. A sample therefore reaches the last integrator four valid clocks after it enters the first.
- R5: A clock with `inValid` low changes no integrator and does not advance the phase counter.
- R6: Counted from reset, each 16th valid sample produces a one-clock pulse on `outValid` in the cycle after that sample's clock edge. No other clock produces a pulse.
- R7: On each 16th valid sample, the 16-bit last-integrator value before that edge passes through five comb stages, each y = x - x(previous decimation instant), modulo 2^16. The result appears on `outData` with the pulse of R6.
- R8: `outData` keeps its value in every cycle in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Qualifies `inData` on this clock |
| inData | input | 5 | Signed input sample |
| outValid | output | 1 | One-clock pulse per decimated result |
| outData | output | 16 | Signed decimated result |

## Verification
The assertions assume that reset is high from the first clock edge. They also assume that `inValid` is a plain qualifier with no handshake, so it may drop for any number of cycles, and that the decimation factor is at least two. The stimulus holds reset from time zero and drives every input on the falling edge. It covers dense streams, streams with every other cycle idle, and a long idle gap just before the sixteenth sample. It also applies resets in the middle of a decimation period. The expected results come from a bit-exact stage-by-stage model that applies the same truncations. That model is fed with steps, impulses and a full-scale alternating pattern at both signs of full scale.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int DEF_STAGES = 5;
  localparam int DEF_INT_W [DEF_STAGES] = '{25, 22, 20, 18, 16};

  typedef struct packed {
    logic intEn;  // integrators advance
    logic pick;   // decimation instant: combs advance
  } cic_strb_t;
endpackage

// File: rtl/cic_ctrl.sv
module cic_ctrl
  import cic_pkg::*;
#(
  parameter int DECIM = 16,
  localparam int PH_W = $clog2(DECIM)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inValid,
  output cic_strb_t       strb,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST = PH_W'(DECIM - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (inValid) begin
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

  always_comb begin
    strb.intEn = inValid;
    strb.pick  = inValid && (phase == LAST);
  end
endmodule

// File: rtl/cic_dp.sv
module cic_dp
  import cic_pkg::*;
#(
  parameter int IN_W   = 5,
  parameter int STAGES = DEF_STAGES,
  parameter int CMB_W  = 16,
  parameter int INT_W [STAGES] = DEF_INT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  cic_strb_t        strb,
  input  logic [IN_W-1:0]  inData,
  output logic             outValid,
  output logic [CMB_W-1:0] outData
);
  localparam int LAST_W = INT_W[STAGES-1];

  // Integrator ladder: each stage adds the registered, truncated value of its predecessor.
  for (genvar k = 0; k < STAGES; k++) begin : gInt
    logic [INT_W[k]-1:0] acc;
    logic [INT_W[k]-1:0] addend;
    if (k == 0) begin : gHead
      assign addend = {{(INT_W[0]-IN_W){inData[IN_W-1]}}, inData};
    end else begin : gBody
      assign addend = gInt[k-1].acc[INT_W[k-1]-1 -: INT_W[k]];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        acc <= '0;
      end else if (strb.intEn) begin
        acc <= acc + addend;
      end
    end
  end

  // Comb section at the decimated rate.
  logic [CMB_W-1:0] cTap [STAGES+1];
  assign cTap[0] = gInt[STAGES-1].acc[LAST_W-1 -: CMB_W];

  for (genvar k = 0; k < STAGES; k++) begin : gCmb
    logic [CMB_W-1:0] dly;
    always_ff @(posedge clk) begin
      if (rst) begin
        dly <= '0;
      end else if (strb.pick) begin
        dly <= cTap[k];
      end
    end
    assign cTap[k+1] = cTap[k] - dly;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strb.pick;
      if (strb.pick) begin
        outData <= cTap[STAGES];
      end
    end
  end
endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
#(
  parameter int IN_W   = 5,
  parameter int STAGES = DEF_STAGES,
  parameter int DECIM  = 16,
  parameter int CMB_W  = 16,
  parameter int INT_W [STAGES] = DEF_INT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [IN_W-1:0]  inData,
  output logic             outValid,
  output logic [CMB_W-1:0] outData
);
  localparam int PH_W = $clog2(DECIM);

  cic_strb_t       strb;
  logic [PH_W-1:0] phase;

  cic_ctrl #(.DECIM(DECIM)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strb    (strb),
    .phase   (phase)
  );

  cic_dp #(
    .IN_W   (IN_W),
    .STAGES (STAGES),
    .CMB_W  (CMB_W),
    .INT_W  (INT_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );
endmodule

// File: rtl/cic_decim_chk.sv
module cic_decim_chk #(
  parameter int DECIM = 16,
  parameter int CMB_W = 16,
  localparam int PH_W = $clog2(DECIM)
) (
  input logic             clk,
  input logic             rst,
  input logic             inValid,
  input logic [PH_W-1:0]  phase,
  input logic             outValid,
  input logic [CMB_W-1:0] outData
);
  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && outData == '0));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(phase));

  // R6
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> ($past(inValid) && $past(phase) == PH_W'(DECIM - 1)));

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && outData != $past(outData)) |-> outValid);
endmodule

bind cic_decim cic_decim_chk #(.DECIM(DECIM), .CMB_W(CMB_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .phase    (phase),
  .outValid (outValid),
  .outData  (outData)
);

// File: tb/cic_decim_tb.sv
`timescale 1ns/1ps
module cic_decim_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [4:0]  inData = '0;
  logic        outValid;
  logic [15:0] outData;

  always #2.5 clk = ~clk;

  cic_decim u_dut (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );

  int checks = 0;
  int errors = 0;

  // Bit-exact reference built from the requirements.
  logic [24:0] m1;
  logic [21:0] m2;
  logic [19:0] m3;
  logic [17:0] m4;
  logic [15:0] m5;
  logic [15:0] md [5];
  int          mcnt;
  bit          pend;
  logic [15:0] expV;

  // kind: 0 step, 1 impulse, 2 step with idle every other cycle, 3 alternating full scale
  localparam int NVEC = 7;
  localparam int VEC [NVEC][3] = '{
    '{0,  15, 256}, '{0, -16, 256}, '{1,  15, 256}, '{1, -16, 256},
    '{2,   7, 256}, '{3,   0, 256}, '{0,  -1, 256}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    m1 = '0; m2 = '0; m3 = '0; m4 = '0; m5 = '0;
    for (int k = 0; k < 5; k++) md[k] = '0;
    mcnt = 0;
    pend = 1'b0;
  endtask

  task automatic modelStep(input logic [4:0] x);
    logic [15:0] u;
    logic [15:0] c;
    if (mcnt == 15) begin
      u = m5;
      for (int k = 0; k < 5; k++) begin
        c = u - md[k];
        md[k] = u;
        u = c;
      end
      expV = u;
      pend = 1'b1;
    end
    m5 = m5 + m4[17:2];
    m4 = m4 + m3[19:2];
    m3 = m3 + m2[21:2];
    m2 = m2 + m1[24:3];
    m1 = m1 + {{20{x[4]}}, x};
    mcnt = (mcnt + 1) % 16;
  endtask

  task automatic observe(input string tag);
    if (pend) begin
      check(outValid === 1'b1 && outData === expV, tag, {15'd0, outValid, outData}, {16'd1, expV});
      pend = 1'b0;
    end else if (outValid !== 1'b0) begin
      check(1'b0, "R6 unexpected pulse", {31'd0, outValid}, 32'd0);
    end
  endtask

  task automatic cycle(input bit v, input logic [4:0] x, input string tag);
    @(negedge clk);
    observe(tag);
    inValid = v;
    inData  = x;
    if (v) modelStep(x);
  endtask

  task automatic doReset();
    @(negedge clk);
    observe("R6");
    rst = 1'b1;
    inValid = 1'b0;
    repeat (2) @(negedge clk);
    check(outValid === 1'b0 && outData === 16'd0, "R1 reset state", {15'd0, outValid, outData}, 32'd0);
    rst = 1'b0;
    modelReset();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] held;
    logic [4:0]  x;
    modelReset();
    repeat (3) @(negedge clk);
    check(outValid === 1'b0 && outData === 16'd0, "R1 initial reset", {15'd0, outValid, outData}, 32'd0);
    rst = 1'b0;

    // Vector table: R2 R3 R4 R7 against the reference; kind 2 also covers R5
    for (int v = 0; v < NVEC; v++) begin
      doReset();
      for (int i = 0; i < VEC[v][2]; i++) begin
        case (VEC[v][0])
          1:       x = (i == 0) ? 5'(VEC[v][1]) : 5'd0;
          3:       x = (i % 2 == 1) ? 5'b10000 : 5'b01111;
          default: x = 5'(VEC[v][1]);
        endcase
        if (VEC[v][0] == 2) begin
          cycle(1'b1, x, "R5 gapped stream");
          cycle(1'b0, 5'd0, "R5 gapped stream");
        end else begin
          cycle(1'b1, x, "R2 R3 R4 R7 stream");
        end
      end
      cycle(1'b0, 5'd0, "R7 flush");
      cycle(1'b0, 5'd0, "R7 flush");
    end

    // R5 R6 R8: idle gap before the 16th sample
    doReset();
    for (int i = 0; i < 15; i++) cycle(1'b1, 5'd9, "R6 early");
    cycle(1'b0, 5'd0, "R6 early");
    held = outData;
    for (int i = 0; i < 40; i++) begin
      cycle(1'b0, 5'd3, "R5 idle");
    end
    @(negedge clk);
    check(outValid === 1'b0, "R5 no pulse during gap", {31'd0, outValid}, 32'd0);
    check(outData === held, "R8 output held", {16'd0, outData}, {16'd0, held});
    cycle(1'b1, 5'd9, "R6 16th sample");
    cycle(1'b0, 5'd0, "R6 pulse value");
    @(negedge clk);
    check(outValid === 1'b0, "R6 pulse one cycle", {31'd0, outValid}, 32'd0);

    // R1: reset in the middle of a decimation period, then resume
    doReset();
    for (int i = 0; i < 40; i++) cycle(1'b1, 5'(-5), "R1 before reset");
    doReset();
    for (int i = 0; i < 80; i++) cycle(1'b1, 5'd3, "R1 after reset");
    cycle(1'b0, 5'd0, "R1 after reset");
    cycle(1'b0, 5'd0, "R1 after reset");

    summary();
    $finish;
  end
endmodule